// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address presented to the array of a synchronous burst SRAM. An external address is captured whenever either of two address-strobe inputs is high at a rising clock edge. After that, the two least significant address bits walk through a four-beat burst. They move one beat on each rising edge where the advance input is high and hold on every other edge. The bits above the low pair stay at their captured value for the whole burst.

A static order-select input picks between two burst orders. In linear order the start value is incremented modulo four. In interleaved order the start value is XORed with the beat number. In both orders the fifth address returns to the start value. Bursting is optional: a fresh address can be strobed in on every cycle without any lost cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `word_addr` is all zeros after the next rising edge.
- R2: A rising edge with `strobe_a` or `strobe_b` high makes `word_addr` equal to `addr_in` right after that edge.
- R3: With both strobes high together, the load is the same as with either strobe alone.
- R4: With `order_ilv` = 0, each advance edge sets the low two bits to (start + beat) mod 4, where beat is the number of advances since the load.
- R5: With `order_ilv` = 1, each advance edge sets the low two bits to start XOR beat.
- R6: The fourth advance after a load returns the low two bits to the loaded start value.
- R7: Advancing never changes `word_addr[ADDR_W-1:2]`. Low bits going from 11 to 00 produce no carry into bit 2.
- R8: When a strobe and `adv` are high on the same edge, the load takes effect and no advance happens.
- R9: An edge with both strobes and `adv` low leaves `word_addr` unchanged.
- R10: A change of `order_ilv` does not alter `word_addr` by itself. The change first shows on the next advance, which uses the existing start and beat count.
- R11: A load on each of several consecutive edges delivers each new address on the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_a | input | 1 | First address-load strobe |
| strobe_b | input | 1 | Second address-load strobe |
| adv | input | 1 | Advance the burst by one beat |
| order_ilv | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Current word address to the array |

## Verification
Full linear and interleaved bursts are run from several start values. These sequences show the difference between add-with-wrap and XOR, and start value 01 gives a different second address in each order. One burst starts at 10 with upper bits all ones, so a missing carry block would show up as a changed upper field. Strobes are driven alone, in pairs, together with advance, and on back-to-back edges, which separates the load priority from the advance path. Idle edges and an order flip with no advance check that the held state is retained and that the flip takes effect only on the next advance.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } seq_cmd_e;
endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
    import burst_addr_pkg::*;
(
    input  logic     strobe_a,
    input  logic     strobe_b,
    input  logic     adv,
    output seq_cmd_e cmd
);
    // Either strobe loads; a load outranks an advance.
    always_comb begin
        if (strobe_a || strobe_b) cmd = CMD_LOAD;
        else if (adv)             cmd = CMD_STEP;
        else                      cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] beat,
    input  logic             order_ilv,
    output logic [LOW_W-1:0] low
);
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    // Per-bit XOR for the interleaved order.
    for (genvar b = 0; b < LOW_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start[b] ^ beat[b];
    end

    // Modulo add for the linear order; the width truncation gives the wrap.
    assign lin_low = start + beat;

    always_comb begin
        low = order_ilv ? ilv_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              adv,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int LOW_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic [ADDR_W-1:LOW_W] hi;
        logic [LOW_W-1:0]      start;
        logic [LOW_W-1:0]      beat;
        logic [LOW_W-1:0]      low;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    seq_cmd_e         cmd;
    logic [LOW_W-1:0] beat_inc;
    logic [LOW_W-1:0] step_low;

    burst_ctl_decode u_decode (
        .strobe_a (strobe_a),
        .strobe_b (strobe_b),
        .adv      (adv),
        .cmd      (cmd)
    );

    assign beat_inc = st_q.beat + LOW_W'(1);

    burst_order_map #(.LOW_W(LOW_W)) u_order (
        .start     (st_q.start),
        .beat      (beat_inc),
        .order_ilv (order_ilv),
        .low       (step_low)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.hi    = addr_in[ADDR_W-1:LOW_W];
                st_d.start = addr_in[LOW_W-1:0];
                st_d.beat  = '0;
                st_d.low   = addr_in[LOW_W-1:0];
            end
            CMD_STEP: begin
                st_d.beat = beat_inc;
                st_d.low  = step_low;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_addr = {st_q.hi, st_q.low};

    // ---------------- assertions ----------------
    logic load_in, just_loaded_q;
    assign load_in = strobe_a || strobe_b;

    always_ff @(posedge clk) begin
        if (!rst_n) just_loaded_q <= 1'b0;
        else        just_loaded_q <= load_in;
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_in |=> word_addr == $past(addr_in)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_in && !adv) |=> $stable(word_addr)); // R9

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_in |=> $stable(word_addr[ADDR_W-1:LOW_W])); // R7

    AST_LIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (just_loaded_q && !load_in && adv && !order_ilv)
        |=> word_addr[LOW_W-1:0] == $past(word_addr[LOW_W-1:0]) + LOW_W'(1)); // R4

    AST_ILV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (just_loaded_q && !load_in && adv && order_ilv)
        |=> word_addr[LOW_W-1:0] == ($past(word_addr[LOW_W-1:0]) ^ LOW_W'(1))); // R5
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_a = 1'b0, strobe_b = 1'b0, adv = 1'b0, order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .adv(adv), .order_ilv(order_ilv), .addr_in(addr_in), .word_addr(word_addr)
    );

    typedef struct packed {
        logic          sa;
        logic          sb;
        logic          av;
        logic          ilv;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,16'h1230,16'h1230,8'd2},  // R2 load via strobe_a
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1231,8'd4},  // R4 linear
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1232,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1233,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1230,8'd6},  // R6 wrap
        '{1'b0,1'b1,1'b0,1'b0,16'hABC6,16'hABC6,8'd2},  // R2 load via strobe_b
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC7,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC4,8'd7},  // R7 no carry
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC5,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC6,8'd6},  // R6
        '{1'b1,1'b0,1'b0,1'b1,16'h00F1,16'h00F1,8'd2},
        '{1'b0,1'b0,1'b1,1'b1,16'h0000,16'h00F0,8'd5},  // R5 interleaved
        '{1'b0,1'b0,1'b1,1'b1,16'h0000,16'h00F3,8'd5},
        '{1'b0,1'b0,1'b1,1'b1,16'h0000,16'h00F2,8'd5},
        '{1'b0,1'b0,1'b1,1'b1,16'h0000,16'h00F1,8'd6},  // R6
        '{1'b0,1'b0,1'b0,1'b1,16'h7777,16'h00F1,8'd9},  // R9 idle hold
        '{1'b1,1'b0,1'b1,1'b0,16'h5553,16'h5553,8'd8},  // R8 load beats advance
        '{1'b1,1'b1,1'b0,1'b0,16'h7772,16'h7772,8'd3},  // R3 both strobes
        '{1'b1,1'b0,1'b0,1'b0,16'h0003,16'h0003,8'd11}, // R11 back-to-back
        '{1'b0,1'b1,1'b0,1'b0,16'hFFFE,16'hFFFE,8'd11},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hFFFF,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hFFFC,8'd7}   // R7
    };

    task automatic check(input logic [AW-1:0] exp, input int req, input string what);
        total++;
        if (word_addr !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, word_addr, exp);
        end
    endtask

    task automatic drive(input logic sa, input logic sb, input logic av,
                         input logic ilv, input logic [AW-1:0] a);
        @(negedge clk);
        strobe_a = sa; strobe_b = sb; adv = av; order_ilv = ilv; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check('0, 1, "reset value");  // R1

        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].sa, VECS[i].sb, VECS[i].av, VECS[i].ilv, VECS[i].addr);
            check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R10: flipping the order alone changes nothing; next advance uses it
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h4441);
        check(16'h4441, 10, "load before order flip");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
        check(16'h4441, 10, "order flip, no advance");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        check(16'h4440, 10, "advance after flip uses XOR");

        // R5 interleaved from start 10
        drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0F02);
        check(16'h0F02, 5, "ilv load start 10");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        check(16'h0F03, 5, "ilv beat1");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        check(16'h0F00, 5, "ilv beat2");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        check(16'h0F01, 5, "ilv beat3");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        check(16'h0F02, 6, "ilv wrap");

        // R1 reset mid-burst
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0; adv = 1'b0;
        @(posedge clk);
        #1;
        check('0, 1, "reset mid-burst");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule